// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel. Software-side logic presents a source address, a destination address, a unit size, a per-side address stepping mode, a single/dual address choice and a unit count, then pulses `start`. The channel latches that setup and issues a stream of memory accesses on a simple request/acknowledge port. It keeps going until the programmed number of units has been moved.

In dual address mode every unit is read from the source and then written to the destination, carrying the read data. In single address mode each access is a read of memory at the source address. The data goes straight to a device, which is told by `dev_ack` that the access is its own. A 16-byte unit is broken into four back-to-back longword accesses.

Two sticky interrupt flags report progress. One rises when half of the programmed units are done, and one rises when all of them are done. A new start clears both flags.

Top module: `dma_xfer_engine`

## Requirements
- R1: After synchronous active-low reset, `busy`, `mem_req`, `dev_ack`, `irq_half` and `irq_done` are all 0.
- R2: A `start` pulse while idle latches the whole setup. `busy` is 1 from the next cycle, and the first access goes to the source address.
- R3: In dual mode (`cfg_dual`=1), each access step reads at the source address (`mem_we`=0) and then writes at the destination address (`mem_we`=1). The write data equals the data returned by the preceding read.
- R4: Size code `cfg_size` is 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 16 bytes. `mem_size` carries 0, 1 or 2 for 1, 2 or 4 bytes. A 16-byte unit is issued as four consecutive 4-byte accesses, each with `mem_size`=2.
- R5: After each completed access on a side, that side's address changes by the access byte count. Mode code 1 adds, mode code 2 subtracts, and codes 0 and 3 leave it unchanged. Source and destination use separate mode codes.
- R6: In single mode (`cfg_dual`=0), each access is a read at the source address with `dev_ack`=1. No write access is issued, and the destination address is not used.
- R7: The channel stops after exactly N units and then drops `busy`. N is `cfg_count`, and a count of 0 means 2^CNT_W units.
- R8: `irq_half` becomes 1 on the completion of the first unit that leaves the remaining count at or below floor(N/2). It stays 1 until the next start.
- R9: `irq_done` becomes 1 in the same cycle that `busy` falls. It stays 1 until the next accepted start, which clears it.
- R10: While `mem_req` is 1 and `mem_ack` is 0, the request, address, write flag and write data stay unchanged in the next cycle.
- R11: A `start` pulse while `busy` is 1 has no effect on the running transfer or its setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer (accepted only while idle) |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_count | input | CNT_W | Unit count (0 means 2^CNT_W) |
| cfg_size | input | 2 | Unit size code |
| cfg_src_mode | input | 2 | Source stepping mode |
| cfg_dst_mode | input | 2 | Destination stepping mode |
| cfg_dual | input | 1 | 1 = dual address mode, 0 = single address mode |
| mem_req | output | 1 | Access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Access address |
| mem_size | output | 2 | Access size code (0/1/2) |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes on this cycle |
| dev_ack | output | 1 | Single-mode access belongs to the device |
| busy | output | 1 | Transfer in progress |
| irq_half | output | 1 | Half of the units done (sticky) |
| irq_done | output | 1 | All units done (sticky) |

## Verification
The assertions assume a few things about the memory side. `mem_ack` is only meaningful while `mem_req` is high. The setup inputs matter only in the cycle a start is accepted. The bench's responder follows both rules: it raises acknowledge only against a live request, sometimes after stall cycles, and it returns read data computed from the address. It changes the setup inputs only around starts, apart from one deliberate start pulse with junk setup during a busy transfer.

// File: rtl/dma_xfer_pkg.sv
// Shared encodings for the DMA transfer engine.
// Assumes: size and mode codes are two bits wide.
package dma_xfer_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_LONG  = 2'd2,
        SZ_BLK16 = 2'd3
    } unit_size_e;

    typedef enum logic [1:0] {
        AM_FIXED = 2'd0,
        AM_INC   = 2'd1,
        AM_DEC   = 2'd2,
        AM_HOLD  = 2'd3
    } addr_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } seq_state_e;

    // Byte count of one bus access of the given access size code.
    function automatic logic [2:0] access_bytes(input logic [1:0] acc);
        return 3'd1 << acc;
    endfunction

endpackage

// File: rtl/dma_addr_gen.sv
// One address register of the channel (source or destination side).
// Loads a start address, then steps it by the access byte count when told.
// Assumes: step_en is only asserted while a transfer is running.
module dma_addr_gen
    import dma_xfer_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [1:0]    load_mode,
    input  logic          step_en,
    input  logic [2:0]    step_bytes,
    output logic [AW-1:0] addr
);
    localparam int PADW = AW - 3;

    logic [AW-1:0] addr_q;
    addr_mode_e    mode_q;
    logic [AW-1:0] delta;

    assign delta = {{PADW{1'b0}}, step_bytes};
    assign addr  = addr_q;

    // Hold the current address and mode; update on load or step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            mode_q <= AM_FIXED;
        end else if (load) begin
            addr_q <= load_addr;
            mode_q <= addr_mode_e'(load_mode);
        end else if (step_en) begin
            case (mode_q)
                AM_INC:  addr_q <= addr_q + delta;
                AM_DEC:  addr_q <= addr_q - delta;
                default: addr_q <= addr_q;
            endcase
        end
    end
endmodule

// File: rtl/dma_unit_counter.sv
// Remaining-unit counter with half-way and end detection.
// A zero count loads as 2^CNT_W. Flags are sticky until the next load.
// Assumes: unit_done pulses once per completed unit while running.
module dma_unit_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_count,
    input  logic             unit_done,
    output logic             last_unit,
    output logic             half_flag,
    output logic             done_flag
);
    localparam int RW = CNT_W + 1;

    logic [RW-1:0] rem_q;
    logic [RW-1:0] half_q;
    logic [RW-1:0] init_cnt;
    logic [RW-1:0] rem_nxt;

    assign init_cnt  = (load_count == '0) ? {1'b1, {CNT_W{1'b0}}}
                                          : {1'b0, load_count};
    assign rem_nxt   = rem_q - 1'b1;
    assign last_unit = (rem_q == {{CNT_W{1'b0}}, 1'b1});

    // Track remaining units and raise the half and end flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q     <= '0;
            half_q    <= '0;
            half_flag <= 1'b0;
            done_flag <= 1'b0;
        end else if (load) begin
            rem_q     <= init_cnt;
            half_q    <= init_cnt >> 1;
            half_flag <= 1'b0;
            done_flag <= 1'b0;
        end else if (unit_done) begin
            rem_q <= rem_nxt;
            if (rem_nxt <= half_q) half_flag <= 1'b1;
            if (last_unit)         done_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/dma_seq_fsm.sv
// Access sequencer: walks read/write phases and 16-byte beats of each unit.
// Assumes: mem_ack is only meaningful while a request is presented.
module dma_seq_fsm
    import dma_xfer_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    cfg_size,
    input  logic          cfg_dual,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    input  logic          last_unit,
    output logic          load,
    output logic          busy,
    output logic          mem_req,
    output logic          mem_we,
    output logic [1:0]    acc_size,
    output logic          sel_dst,
    output logic          src_step,
    output logic          dst_step,
    output logic          unit_done,
    output logic          dev_ack,
    output logic [DW-1:0] data_q
);
    localparam logic [1:0] LAST_BEAT = 2'd3;

    seq_state_e state_q;
    seq_state_e state_d;
    unit_size_e size_q;
    logic       dual_q;
    logic [1:0] beat_q;
    logic [1:0] beat_d;
    logic       phase_end;
    logic       is_block;

    assign is_block = (size_q == SZ_BLK16);
    assign load     = start && (state_q == ST_IDLE);
    assign busy     = (state_q != ST_IDLE);
    assign mem_req  = busy;
    assign mem_we   = (state_q == ST_WR);
    assign sel_dst  = (state_q == ST_WR);
    assign dev_ack  = (state_q == ST_RD) && !dual_q;
    assign acc_size = is_block ? SZ_LONG : size_q;
    assign src_step = (state_q == ST_RD) && mem_ack;
    assign dst_step = (state_q == ST_WR) && mem_ack;

    // A beat ends after the read in single mode, after the write in dual mode.
    assign phase_end = dual_q ? dst_step : src_step;

    // Pick the next phase, beat index and unit completion.
    always_comb begin
        state_d   = state_q;
        beat_d    = beat_q;
        unit_done = 1'b0;
        case (state_q)
            ST_IDLE: if (load) begin
                state_d = ST_RD;
                beat_d  = '0;
            end
            default: begin
                if (src_step && dual_q) state_d = ST_WR;
                if (phase_end) begin
                    if (is_block && beat_q != LAST_BEAT) begin
                        beat_d  = beat_q + 1'b1;
                        state_d = ST_RD;
                    end else begin
                        beat_d    = '0;
                        unit_done = 1'b1;
                        state_d   = last_unit ? ST_IDLE : ST_RD;
                    end
                end
            end
        endcase
    end

    // Register phase, beat and the setup latched at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            size_q  <= SZ_BYTE;
            dual_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
            if (load) begin
                size_q <= unit_size_e'(cfg_size);
                dual_q <= cfg_dual;
            end
        end
    end

    // Capture read data for the following write.
    always_ff @(posedge clk) begin
        if (!rst_n)        data_q <= '0;
        else if (src_step) data_q <= mem_rdata;
    end
endmodule

// File: rtl/dma_xfer_engine.sv
// Top of the single-channel DMA transfer engine.
// Ties the sequencer, the unit counter and the two address generators.
// Assumes: setup inputs are only sampled on an accepted start.
module dma_xfer_engine
    import dma_xfer_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    cfg_src,
    input  logic [AW-1:0]    cfg_dst,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic [1:0]       cfg_size,
    input  logic [1:0]       cfg_src_mode,
    input  logic [1:0]       cfg_dst_mode,
    input  logic             cfg_dual,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [1:0]       mem_size,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             mem_ack,
    output logic             dev_ack,
    output logic             busy,
    output logic             irq_half,
    output logic             irq_done
);
    localparam int SIDES = 2;

    logic          load;
    logic          sel_dst;
    logic          src_step;
    logic          dst_step;
    logic          unit_done;
    logic          last_unit;
    logic [1:0]    acc_size;
    logic [2:0]    step_bytes;
    logic [AW-1:0] side_addr  [SIDES];
    logic [AW-1:0] side_start [SIDES];
    logic [1:0]    side_mode  [SIDES];
    logic          side_step  [SIDES];

    assign side_start[0] = cfg_src;
    assign side_start[1] = cfg_dst;
    assign side_mode[0]  = cfg_src_mode;
    assign side_mode[1]  = cfg_dst_mode;
    assign side_step[0]  = src_step;
    assign side_step[1]  = dst_step;
    assign step_bytes    = access_bytes(acc_size);
    assign mem_addr      = sel_dst ? side_addr[1] : side_addr[0];
    assign mem_size      = acc_size;

    dma_seq_fsm #(.DW(DW)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cfg_size  (cfg_size),
        .cfg_dual  (cfg_dual),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .last_unit (last_unit),
        .load      (load),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .acc_size  (acc_size),
        .sel_dst   (sel_dst),
        .src_step  (src_step),
        .dst_step  (dst_step),
        .unit_done (unit_done),
        .dev_ack   (dev_ack),
        .data_q    (mem_wdata)
    );

    dma_unit_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_count (cfg_count),
        .unit_done  (unit_done),
        .last_unit  (last_unit),
        .half_flag  (irq_half),
        .done_flag  (irq_done)
    );

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        dma_addr_gen #(.AW(AW)) addr_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (load),
            .load_addr  (side_start[s]),
            .load_mode  (side_mode[s]),
            .step_en    (side_step[s]),
            .step_bytes (step_bytes),
            .addr       (side_addr[s])
        );
    end
endmodule

// File: rtl/dma_xfer_engine_chk.sv
// Protocol checker for the DMA transfer engine, bound to the top module.
// Assumes: the memory side only acknowledges live requests.
module dma_xfer_engine_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          mem_req,
    input logic          mem_ack,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          dev_ack,
    input logic          irq_half,
    input logic          irq_done
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req && !dev_ack); // R7
    AST_SINGLE_READS: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack |-> !mem_we); // R6
    AST_HALF_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> irq_half); // R8
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done && !start |=> irq_done); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> !busy); // R9
    AST_BUSY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !mem_ack |=> busy); // R11
endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(.AW(AW), .DW(DW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .dev_ack   (dev_ack),
    .irq_half  (irq_half),
    .irq_done  (irq_done)
);

// File: tb/dma_xfer_engine_tb_top.sv
// Scoreboard bench: the driver predicts every access, the monitor compares.
module dma_xfer_engine_tb_top;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 8;

    typedef struct {
        logic          we;
        logic [AW-1:0] addr;
        logic [1:0]    size;
        logic [DW-1:0] wdata;
        logic          dev;
        logic          half;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] cfg_src = '0;
    logic [AW-1:0] cfg_dst = '0;
    logic [CW-1:0] cfg_count = '0;
    logic [1:0]    cfg_size = '0;
    logic [1:0]    cfg_src_mode = '0;
    logic [1:0]    cfg_dst_mode = '0;
    logic          cfg_dual = 1'b0;
    logic          mem_req, mem_we, dev_ack, busy, irq_half, irq_done;
    logic [AW-1:0] mem_addr;
    logic [1:0]    mem_size;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_ack = 1'b0;
    logic          stall_en = 1'b0;
    int            tick = 0;
    int            checks = 0;
    int            errors = 0;
    item_t         exp_q[$];

    always #5 clk = ~clk;

    dma_xfer_engine #(.AW(AW), .DW(DW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_count(cfg_count),
        .cfg_size(cfg_size), .cfg_src_mode(cfg_src_mode),
        .cfg_dst_mode(cfg_dst_mode), .cfg_dual(cfg_dual),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .dev_ack(dev_ack), .busy(busy),
        .irq_half(irq_half), .irq_done(irq_done)
    );

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return ~a ^ 32'h1357_9BDF;
    endfunction

    function automatic logic [AW-1:0] stepped(input logic [AW-1:0] a,
                                              input logic [1:0] mode,
                                              input int bytes);
        if (mode == 2'd1) return a + AW'(bytes);
        if (mode == 2'd2) return a - AW'(bytes);
        return a;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Memory responder: acknowledges live requests, optionally with stalls.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            tick++;
            mem_ack   = (mem_req === 1'b1) && (!stall_en || (tick % 3 != 0));
            mem_rdata = pat(mem_addr);
        end
    end

    // Monitor: compare every completed access against the prediction.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_req === 1'b1 && mem_ack) begin
                if (exp_q.size() == 0) begin
                    check(0, "R7", "unexpected access", mem_addr, '0);
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    check(mem_we == e.we, e.we ? "R3" : "R6", "write flag",
                          AW'(mem_we), AW'(e.we));
                    check(mem_addr == e.addr, "R5", "address", mem_addr, e.addr);
                    check(mem_size == e.size, "R4", "size", AW'(mem_size), AW'(e.size));
                    check(dev_ack == e.dev, "R6", "device ack", AW'(dev_ack), AW'(e.dev));
                    check(irq_half == e.half, "R8", "half flag", AW'(irq_half), AW'(e.half));
                    if (e.we) check(mem_wdata == e.wdata, "R3", "write data",
                                    mem_wdata, e.wdata);
                end
            end
        end
    end

    // Driver: predict the access list, start, and wait for the end.
    task automatic run_xfer(input logic [AW-1:0] src, input logic [AW-1:0] dst,
                            input logic [CW-1:0] cnt, input logic [1:0] size,
                            input logic [1:0] smode, input logic [1:0] dmode,
                            input logic dual, input bit poke);
        int n, beats, bytes;
        logic [AW-1:0] s, d;
        logic [1:0] acc;
        n     = (cnt == 0) ? (1 << CW) : int'(cnt);
        beats = (size == 2'd3) ? 4 : 1;
        acc   = (size == 2'd3) ? 2'd2 : size;
        bytes = 1 << acc;
        s = src;
        d = dst;
        for (int u = 0; u < n; u++) begin
            for (int b = 0; b < beats; b++) begin
                item_t it;
                it.we = 1'b0; it.addr = s; it.size = acc; it.wdata = '0;
                it.dev = !dual;
                it.half = (u >= 1) && ((n - u) <= (n / 2));
                exp_q.push_back(it);
                if (dual) begin
                    item_t wt;
                    wt.we = 1'b1; wt.addr = d; wt.size = acc; wt.wdata = pat(s);
                    wt.dev = 1'b0; wt.half = it.half;
                    exp_q.push_back(wt);
                    d = stepped(d, dmode, bytes);
                end
                s = stepped(s, smode, bytes);
            end
        end
        @(posedge clk); #2;
        cfg_src = src; cfg_dst = dst; cfg_count = cnt; cfg_size = size;
        cfg_src_mode = smode; cfg_dst_mode = dmode; cfg_dual = dual;
        start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
        cfg_src = 32'hDEAD_0000; cfg_count = 8'd1; cfg_size = 2'd0;
        @(negedge clk);
        check(busy == 1'b1, "R2", "busy after start", AW'(busy), 1);
        check(irq_done == 1'b0, "R9", "done cleared by start", AW'(irq_done), 0);
        if (poke) begin
            repeat (3) @(posedge clk);
            #2;
            cfg_src = 32'hBAD0_0000; cfg_dual = !dual; cfg_count = 8'd1;
            start = 1'b1;
            @(posedge clk); #2;
            start = 1'b0;
        end
        for (int w = 0; w < 20000 && busy; w++) @(negedge clk);
        check(busy == 1'b0, "R7", "busy after run", AW'(busy), 0);
        check(exp_q.size() == 0, poke ? "R11" : "R7", "accesses left over",
              AW'(exp_q.size()), 0);
        check(irq_done == 1'b1, "R9", "done flag", AW'(irq_done), 1);
        check(irq_half == 1'b1, "R8", "half flag at end", AW'(irq_half), 1);
        exp_q.delete();
        repeat (2) @(negedge clk);
        check(irq_done == 1'b1, "R9", "done flag holds", AW'(irq_done), 1);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(busy == 0, "R1", "busy", AW'(busy), 0);
        check(mem_req == 0, "R1", "mem_req", AW'(mem_req), 0);
        check(dev_ack == 0, "R1", "dev_ack", AW'(dev_ack), 0);
        check(irq_half == 0 && irq_done == 0, "R1", "irq flags",
              AW'({irq_half, irq_done}), 0);
        // R2 R3 R5: dual longword, both sides increment
        run_xfer(32'h0000_1000, 32'h0000_2000, 8'd4, 2'd2, 2'd1, 2'd1, 1'b1, 0);
        // R4 R5 R10: dual byte, source decrements, destination fixed, stalls
        stall_en = 1'b1;
        run_xfer(32'h0000_3007, 32'h0000_4000, 8'd5, 2'd0, 2'd2, 2'd0, 1'b1, 0);
        // R4 R5: dual word, source fixed (code 3), destination increments
        run_xfer(32'h0000_5000, 32'h0000_6002, 8'd3, 2'd1, 2'd3, 2'd1, 1'b1, 0);
        // R4: 16-byte units as four longwords, destination decrements
        run_xfer(32'h0000_7000, 32'h0000_8100, 8'd2, 2'd3, 2'd1, 2'd2, 1'b1, 0);
        stall_en = 1'b0;
        // R6: single mode longword and 16-byte
        run_xfer(32'h0000_9000, 32'hFFFF_0000, 8'd3, 2'd2, 2'd1, 2'd1, 1'b0, 0);
        run_xfer(32'h0000_A000, 32'hFFFF_0000, 8'd1, 2'd3, 2'd1, 2'd1, 1'b0, 0);
        // R8: count of one, half and done together
        run_xfer(32'h0000_B000, 32'h0000_C000, 8'd1, 2'd1, 2'd1, 2'd1, 1'b1, 0);
        // R11: start while busy ignored
        run_xfer(32'h0000_D000, 32'h0000_E000, 8'd6, 2'd2, 2'd1, 2'd1, 1'b1, 1);
        // R7: zero count means 2^CNT_W units
        run_xfer(32'h0000_F000, 32'h0000_0000, 8'd0, 2'd0, 2'd0, 2'd0, 1'b0, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule